// File: doc/BRIEF.md
# Chained Serial DAC Write Controller

This block is the host side of a write-only serial link to a chain of two-channel, 12-bit serial converters. All converters share one serial clock and one active-low select line that also acts as the load strobe on its rising edge. Each converter's serial output feeds the next converter's serial input. The controller accepts one request carrying a code for every channel of every device. It shifts all the bits out back to back. It then raises the select line once, so that every device updates its outputs at the same moment.

Requests arrive on a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole transfer, so no back-pressure state is held outside the block. A requester that keeps `req_valid` high while the block is busy has no effect until the transfer completes.

The serial clock is derived from the system clock by a divider parameter. Every interface minimum is converted to a cycle count from a system-clock-period parameter. Those minimums are: setup, clock high and low times, select-to-clock, last-clock-to-load, and load pulse width. The divider can only stretch these counts, never shorten them.

Top module: `dchain_dac_host`

## Requirements
- R1: While reset is held and after it is released, `cs_ld` is 1, `sclk` is 0, `busy` is 0, `done` is 0 and `req_ready` is 1.
- R2: The code of device d (device 0 is nearest the controller) and channel c (0 = A, 1 = B) is `req_codes[(2*d+c)*12 +: 12]`. Frames go out from device N_DEV-1 down to device 0. Within a frame, channel A is sent MSB first, then channel B MSB first. After the load, device d's shift register therefore holds its own A and B codes.
- R3: A transfer has exactly 24*N_DEV rising edges of `sclk`. All of them occur while `cs_ld` is low, and `cs_ld` rises only after the last of them.
- R4: `sclk` is low in the cycle before `cs_ld` falls and in the cycle in which it falls. The first rising `sclk` edge comes no sooner than max(ceil(20 ns), ceil(40 ns)) system cycles after `cs_ld` falls.
- R5: `sdata` changes only while `sclk` is low. It is stable for at least ceil(40 ns) cycles before every rising `sclk` edge.
- R6: The `sclk` high phase lasts max(SCLK_DIV/2, ceil(40 ns)) cycles. Each low phase between two rising edges lasts max(SCLK_DIV - SCLK_DIV/2, ceil(40 ns)) cycles.
- R7: At least ceil(40 ns) cycles pass from the last rising `sclk` edge to the rise of `cs_ld`. `cs_ld` stays high for at least ceil(50 ns) cycles.
- R8: `req_ready` equals the inverse of `busy`. A request presented while busy is ignored: it neither starts a transfer nor changes the codes being sent.
- R9: `done` is a one-cycle pulse exactly ceil(50 ns) cycles after `cs_ld` rises. `busy` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller can take a request |
| req_codes | input | 2*N_DEV*CODE_W | All channel codes, device 0 channel A in the low bits |
| sclk | output | 1 | Serial clock to the chain |
| sdata | output | 1 | Serial data to the first device |
| cs_ld | output | 1 | Active-low select; its rising edge loads all devices |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench models the chain as one long shift register that is clocked on rising `sclk`. It compares each device's slice against the codes it sent at every load. All-zero and all-one words confirm the bit count and the idle levels. A single one walked through all 48 bit positions pins every bit to its device, channel and significance, so it separates a swapped channel, reversed bit order or reversed device order. A dense arithmetic pattern and a request pushed in mid-transfer with inverted codes show that requests made while busy cannot disturb the word in flight. Phase widths, setup, select-to-clock, last-clock-to-load and done timing are measured in system cycles on every transfer.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_LOAD
  } dcd_state_e;

  // Round a nanosecond minimum up to whole system-clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dcd_frame_pack.sv
// Packs per-channel codes into the serial word: farthest device first,
// channel A before channel B, MSB first throughout.
module dcd_frame_pack #(
  parameter int N_DEV  = 2,
  parameter int CODE_W = 12,
  localparam int FRAME_W = 2 * CODE_W,
  localparam int TOTAL_W = N_DEV * FRAME_W
) (
  input  logic [TOTAL_W-1:0] codes,
  output logic [TOTAL_W-1:0] frame
);
  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    for (genvar c = 0; c < 2; c++) begin : g_ch
      assign frame[d*FRAME_W + (1-c)*CODE_W +: CODE_W] = codes[(2*d+c)*CODE_W +: CODE_W];
    end
  end
endmodule

// File: rtl/dcd_phase_timer.sv
// Down counter that marks the end of each interface phase.
module dcd_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (load)           count <= load_val;
    else if (count != '0)    count <= count - 1'b1;
  end

  assign expired = (count == '0);
endmodule

// File: rtl/dcd_bit_shifter.sv
// Holds the outgoing word and counts the bits still to be clocked out.
module dcd_bit_shifter #(
  parameter int TOTAL_W = 48,
  localparam int BC_W = $clog2(TOTAL_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TOTAL_W-1:0] load_word,
  input  logic               advance,
  output logic               sdata,
  output logic               last_bit
);
  logic [TOTAL_W-1:0] shreg;
  logic [BC_W-1:0]    bits_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bits_left <= '0;
    end else if (load) begin
      shreg     <= load_word;
      bits_left <= BC_W'(TOTAL_W - 1);
    end else if (advance) begin
      shreg     <= {shreg[TOTAL_W-2:0], 1'b0};
      bits_left <= bits_left - 1'b1;
    end
  end

  assign sdata    = shreg[TOTAL_W-1];
  assign last_bit = (bits_left == '0);

  // R3: never step past the final bit of the word
  a_r3_no_shift_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> bits_left != '0);
endmodule

// File: rtl/dchain_dac_host.sv
module dchain_dac_host
  import dcd_pkg::*;
#(
  parameter int N_DEV          = 2,
  parameter int CODE_W         = 12,
  parameter int SCLK_DIV       = 16,
  parameter int SYS_PERIOD_PS  = 5000,
  parameter int T_SETUP_NS     = 40,
  parameter int T_CLK_HI_NS    = 40,
  parameter int T_CLK_LO_NS    = 40,
  parameter int T_SEL_CLK_NS   = 20,
  parameter int T_LAST_LD_NS   = 40,
  parameter int T_LD_PULSE_NS  = 50,
  localparam int TOTAL_W = N_DEV * 2 * CODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [TOTAL_W-1:0] req_codes,
  output logic               sclk,
  output logic               sdata,
  output logic               cs_ld,
  output logic               busy,
  output logic               done
);
  localparam int unsigned SETUP_C = ns_to_cyc(T_SETUP_NS, SYS_PERIOD_PS);
  localparam int unsigned HI_CYC  = umax(umax(SCLK_DIV / 2, ns_to_cyc(T_CLK_HI_NS, SYS_PERIOD_PS)), 1);
  localparam int unsigned LO_CYC  = umax(umax(SCLK_DIV - SCLK_DIV / 2,
                                              ns_to_cyc(T_CLK_LO_NS, SYS_PERIOD_PS)),
                                         umax(SETUP_C, 1));
  localparam int unsigned LEAD_CYC  = umax(umax(ns_to_cyc(T_SEL_CLK_NS, SYS_PERIOD_PS), SETUP_C), 1);
  localparam int unsigned LAST_C    = ns_to_cyc(T_LAST_LD_NS, SYS_PERIOD_PS);
  localparam int unsigned TAIL_CYC  = (LAST_C > HI_CYC) ? (LAST_C - HI_CYC) : 1;
  localparam int unsigned PULSE_CYC = umax(ns_to_cyc(T_LD_PULSE_NS, SYS_PERIOD_PS), 1);
  localparam int unsigned MAX_CYC   = umax(umax(umax(HI_CYC, LO_CYC), umax(LEAD_CYC, TAIL_CYC)), PULSE_CYC);
  localparam int TMR_W = $clog2(MAX_CYC + 1);

  dcd_state_e         st;
  logic               sclk_q, cs_q, done_q;
  logic               accept, tmr_done, tmr_load, last_bit, advance;
  logic [TMR_W-1:0]   tmr_val;
  logic [TOTAL_W-1:0] frame;

  assign busy      = (st != ST_IDLE);
  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign advance   = (st == ST_HIGH) && tmr_done && !last_bit;

  dcd_frame_pack #(.N_DEV(N_DEV), .CODE_W(CODE_W)) u_pack (
    .codes (req_codes),
    .frame (frame)
  );

  dcd_phase_timer #(.CNT_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  dcd_bit_shifter #(.TOTAL_W(TOTAL_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_word (frame),
    .advance   (advance),
    .sdata     (sdata),
    .last_bit  (last_bit)
  );

  // Length of the phase entered on this transition.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (st)
      ST_IDLE: if (accept)   begin tmr_load = 1'b1; tmr_val = TMR_W'(LEAD_CYC - 1); end
      ST_LEAD: if (tmr_done) begin tmr_load = 1'b1; tmr_val = TMR_W'(HI_CYC - 1);   end
      ST_HIGH: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = last_bit ? TMR_W'(TAIL_CYC - 1) : TMR_W'(LO_CYC - 1);
      end
      ST_LOW:  if (tmr_done) begin tmr_load = 1'b1; tmr_val = TMR_W'(HI_CYC - 1);    end
      ST_TAIL: if (tmr_done) begin tmr_load = 1'b1; tmr_val = TMR_W'(PULSE_CYC - 1); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (accept)   begin cs_q <= 1'b0;   st <= ST_LEAD; end
        ST_LEAD: if (tmr_done) begin sclk_q <= 1'b1; st <= ST_HIGH; end
        ST_HIGH: if (tmr_done) begin
          sclk_q <= 1'b0;
          st     <= last_bit ? ST_TAIL : ST_LOW;
        end
        ST_LOW:  if (tmr_done) begin sclk_q <= 1'b1; st <= ST_HIGH; end
        ST_TAIL: if (tmr_done) begin cs_q <= 1'b1;   st <= ST_LOAD; end
        ST_LOAD: if (tmr_done) begin done_q <= 1'b1; st <= ST_IDLE; end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sclk  = sclk_q;
  assign cs_ld = cs_q;
  assign done  = done_q;

  // R4: select may only fall with the serial clock already low
  a_r4_clk_low_at_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_ld) |-> (!sclk && !$past(sclk)));
  // R3: every rising clock edge happens inside the selected window
  a_r3_clock_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_ld);
  // R5: data moves only while the clock is low
  a_r5_data_moves_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> !sclk);
  // R8: no acceptance while a transfer is running
  a_r8_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: done only after the load strobe has been high
  a_r9_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_ld && $past(cs_ld)));
endmodule

// File: tb/dchain_dac_host_bench.sv
`timescale 1ns/1ps
module dchain_dac_host_bench;
  localparam int NDEV   = 2;
  localparam int CW     = 12;
  localparam int DIV    = 21;
  localparam int PER_PS = 5000;
  localparam int TOTAL  = NDEV * 2 * CW;

  localparam int SETUP_C = (40 * 1000 + PER_PS - 1) / PER_PS;
  localparam int SEL_C   = (20 * 1000 + PER_PS - 1) / PER_PS;
  localparam int LEAD_C  = (SEL_C > SETUP_C) ? SEL_C : SETUP_C;
  localparam int MINW_C  = (40 * 1000 + PER_PS - 1) / PER_PS;
  localparam int EXP_HI  = (DIV / 2 > MINW_C) ? DIV / 2 : MINW_C;
  localparam int EXP_LO  = (DIV - DIV / 2 > MINW_C) ? DIV - DIV / 2 : MINW_C;
  localparam int LAST_C  = (40 * 1000 + PER_PS - 1) / PER_PS;
  localparam int PULSE_C = (50 * 1000 + PER_PS - 1) / PER_PS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [TOTAL-1:0] req_codes = '0;
  logic sclk, sdata, cs_ld, busy, done;

  always #2.5 clk = ~clk;

  dchain_dac_host #(.N_DEV(NDEV), .CODE_W(CW), .SCLK_DIV(DIV), .SYS_PERIOD_PS(PER_PS)) u_dchain_dac_host (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_codes(req_codes), .sclk(sclk), .sdata(sdata), .cs_ld(cs_ld),
    .busy(busy), .done(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  int xfers = 0;
  int sent = 0;
  logic mon_en = 1'b0;
  logic [TOTAL-1:0] exp_codes = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Chain monitor: a shift register clocked on rising sclk models the devices.
  logic p_sclk, p_cs, p_sdata, p_done;
  int c_tog, c_data, c_cs, c_rise, c_csr, rises;
  logic [TOTAL-1:0] chain;

  always @(negedge clk) begin
    if (!mon_en) begin
      p_sclk = sclk; p_cs = cs_ld; p_sdata = sdata; p_done = done;
      c_tog = 1000; c_data = 1000; c_cs = 1000; c_rise = 1000; c_csr = 1000;
      rises = 0; chain = '0;
    end else begin
      automatic bit rise = sclk && !p_sclk;
      automatic bit fall = !sclk && p_sclk;
      automatic bit csf  = !cs_ld && p_cs;
      automatic bit csr  = cs_ld && !p_cs;
      automatic bit dchg = (sdata != p_sdata);

      chk(req_ready == !busy, "R8 ready is inverse of busy", req_ready, !busy);
      if (csf) begin
        chk(!p_sclk && !sclk, "R4 clock low at select fall", sclk, 0);
        chk(c_csr >= PULSE_C, "R7 load pulse width", c_csr, PULSE_C);
        rises = 0;
      end
      if (dchg) chk(!sclk, "R5 data changes only with clock low", sclk, 0);
      if (rise) begin
        chk(!cs_ld, "R3 clock edge only while selected", cs_ld, 0);
        chk(c_data >= SETUP_C, "R5 data setup before rising edge", c_data, SETUP_C);
        if (rises == 0) chk(c_cs >= LEAD_C, "R4 select to first clock", c_cs, LEAD_C);
        else            chk(c_tog == EXP_LO, "R6 clock low width", c_tog, EXP_LO);
        chain = {chain[TOTAL-2:0], sdata};
        rises++;
      end
      if (fall) chk(c_tog == EXP_HI, "R6 clock high width", c_tog, EXP_HI);
      if (csr) begin
        chk(rises == TOTAL, "R3 rising edges per transfer", rises, TOTAL);
        chk(c_rise >= LAST_C, "R7 last clock to load", c_rise, LAST_C);
        for (int d = 0; d < NDEV; d++) begin
          for (int c = 0; c < 2; c++) begin
            automatic int got = int'(chain[d*2*CW + (1-c)*CW +: CW]);
            automatic int exv = int'(exp_codes[(2*d+c)*CW +: CW]);
            chk(got == exv, "R2 device channel code after load", got, exv);
          end
        end
        xfers++;
      end
      if (done) begin
        chk(!p_done, "R9 done lasts one cycle", p_done, 0);
        chk(c_csr == PULSE_C, "R9 done timing after load rise", c_csr, PULSE_C);
        chk(!busy, "R9 busy falls with done", busy, 0);
      end
      c_tog  = (rise || fall) ? 1 : c_tog + 1;
      c_data = dchg ? 1 : c_data + 1;
      c_cs   = csf ? 1 : c_cs + 1;
      c_rise = rise ? 1 : c_rise + 1;
      c_csr  = csr ? 1 : c_csr + 1;
      p_sclk = sclk; p_cs = cs_ld; p_sdata = sdata; p_done = done;
    end
  end

  task automatic send(input logic [TOTAL-1:0] codes, input bit poke);
    @(negedge clk);
    req_codes = codes;
    exp_codes = codes;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    sent++;
    chk(busy, "R8 request accepted when ready", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      req_codes = ~codes;
      req_valid = 1'b1;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(!req_ready, "R8 not ready during transfer", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(cs_ld && !busy, "R8 ignored request starts nothing", cs_ld, 1);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [TOTAL-1:0] w;
    repeat (3) @(negedge clk);
    // R1: idle levels during reset
    chk(cs_ld == 1'b1, "R1 select high in reset", cs_ld, 1);
    chk(sclk == 1'b0, "R1 clock low in reset", sclk, 0);
    chk(!busy && !done && req_ready, "R1 idle status in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_ld && !sclk && !busy && !done && req_ready, "R1 idle after reset", cs_ld, 1);
    mon_en = 1'b1;
    repeat (2) @(negedge clk);

    send('0, 1'b0);
    send('1, 1'b0);
    for (int i = 0; i < TOTAL; i++) begin
      w = '0;
      w[i] = 1'b1;
      send(w, 1'b0);
    end
    for (int k = 0; k < 2 * NDEV; k++) w[k*CW +: CW] = CW'((k * 291 + 7) % 4096);
    send(w, 1'b0);
    send(w, 1'b1);
    send({(TOTAL/2){2'b10}}, 1'b1);

    repeat (20) @(negedge clk);
    chk(xfers == sent, "R8 one load per accepted request", xfers, sent);
    report();
    $finish;
  end
endmodule